// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block recovers basic frame alignment from a serial E1 receive stream of 256 bits per frame, which is 32 time slots of 8 bits. Each received bit comes with a one-cycle valid strobe, and gaps between bits are allowed. The block hunts bit by bit for the 7-bit alignment word. It confirms a candidate in three steps, then tracks the alignment and drops it after repeated errors. While it holds alignment it gives every received bit its position in the frame and tells alignment frames apart from the frames in between.

Downstream logic uses the active-low sync flag, the frame-start pulse, the bit position and the frame parity to pick out time slots. While alignment is missing the block holds the multiframe aligners in reset, and it tells the far end through the transmit remote alarm bit. A manual reframe request drops alignment at once. The new search does not start until the current alignment position has gone past.

Top module: `e1_basic_framer`

## Requirements
- R1: During reset and just after it, sync_no=1, tx_rai_o=1, mf_rst_o=1, frame_start_o=0, bit_pos_o=0 and fas_frame_o=0.
- R2: While hunting, every accepted bit is tested as the last bit of the alignment word 0011011 (first-received bit first), so every bit offset is tried. A match marks that bit as position 7 of an alignment frame.
- R3: After a candidate, the bit at position 1 of the next frame's time slot 0 (bit two of the non-alignment word) is checked. If it is 0, the candidate is rejected and alignment is not declared at the following alignment word.
- R4: When that bit is 1 and the alignment word 0011011 is also found at positions 1..7 of the frame after it, sync_no goes low in the cycle after position 7 of that word is accepted, with bit_pos_o=7 and fas_frame_o=1.
- R5: bit_pos_o is the position (0..255) of the last accepted bit. It advances by one per valid bit and wraps from 255 to 0. fas_frame_o (1 = alignment frame) toggles on the wrap. Neither changes in a cycle with no valid bit.
- R6: frame_start_o is a one-cycle pulse in the cycle after a position-0 bit is accepted while aligned.
- R7: While aligned, the block checks the alignment word in alignment frames and bit two of time slot 0 in the other frames. Three consecutive failed checks drop alignment right after the third. A passing check clears the count.
- R8: A reframe request raises sync_no on the next cycle. The search resumes only after the bit at position 7 of the next alignment frame has passed. With an unchanged stream, realignment therefore completes at the third alignment word after the request.
- R9: After any automatic failure (loss, a rejected bit two, or a wrong confirming word) the hunt resumes with the very next bit. With an aligned stream, the next correct alignment word becomes the new candidate.
- R10: tx_rai_o and mf_rst_o are 1 whenever sync_no is 1, and 0 while aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received serial data bit |
| rx_valid_i | input | 1 | Strobe: rx_bit_i carries a bit this cycle |
| reframe_i | input | 1 | Manual reframe request |
| sync_no | output | 1 | Basic alignment held, active low |
| frame_start_o | output | 1 | Pulse after bit 0 of a frame while aligned |
| fas_frame_o | output | 1 | Current frame carries the alignment word |
| bit_pos_o | output | 8 | Position of the last accepted bit in the frame |
| tx_rai_o | output | 1 | Remote alarm bit value to transmit |
| mf_rst_o | output | 1 | Reset to the multiframe aligners |

## Verification
A wrong control state shows up on sync_no at a time slot 0 boundary, so the error appears within one frame of the word that should have caused a change. A slipped position counter shows at once as a mismatch between bit_pos_o and the bench's own frame position, and as frame_start_o pulsing on a bit other than position 0. Reframe handling is told apart by which of the following alignment words brings sync_no low: the second when the hold is missing, the third when it is correct.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  localparam int FAS_LEN = 7;
  localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_NFAS,
    ST_CONF,
    ST_LOCK,
    ST_HOLD
  } fa_state_e;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-2:0] sr_q;

  // newest bit at LSB; reset to ones so no false pattern before fill
  assign win_o = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (shift_i) sr_q <= win_o[W-2:0];
  end
endmodule

// File: rtl/e1fa_pos_cnt.sv
module e1fa_pos_cnt #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 7,
  localparam int PW        = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          load_i,
  output logic [PW-1:0] pos_o,
  output logic          fas_o,
  output logic [PW-1:0] nxt_pos_o,
  output logic          nxt_fas_o
);
  logic [PW-1:0] pos_q;
  logic          fas_q;
  logic          at_end;

  assign at_end    = (pos_q == PW'(FRAME_BITS - 1));
  assign nxt_pos_o = at_end ? '0 : pos_q + 1'b1;
  assign nxt_fas_o = fas_q ^ at_end;
  assign pos_o     = pos_q;
  assign fas_o     = fas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fas_q <= 1'b0;
    end else if (adv_i) begin
      if (load_i) begin
        pos_q <= PW'(LOAD_POS);
        fas_q <= 1'b1;
      end else begin
        pos_q <= nxt_pos_o;
        fas_q <= nxt_fas_o;
      end
    end
  end
endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
#(
  parameter int LOSS_LIMIT = 3,
  localparam int MW        = $clog2(LOSS_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic reframe_i,
  input  logic chk_i,
  input  logic fas_frame_i,
  input  logic fas_ok_i,
  input  logic nfas_ok_i,
  output logic load_o,
  output logic locked_o
);
  fa_state_e state_q, state_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          word_ok;

  assign word_ok  = fas_frame_i ? fas_ok_i : nfas_ok_i;
  assign locked_o = (state_q == ST_LOCK);

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    load_o  = 1'b0;
    if (reframe_i) begin
      // no alignment held while hunting: keep hunting
      state_d = (state_q == ST_HUNT) ? ST_HUNT : ST_HOLD;
      miss_d  = '0;
    end else if (valid_i) begin
      unique case (state_q)
        ST_HUNT: if (fas_ok_i) begin
          state_d = ST_NFAS;
          load_o  = 1'b1;
        end
        ST_NFAS: if (chk_i) state_d = nfas_ok_i ? ST_CONF : ST_HUNT;
        ST_CONF: if (chk_i) begin
          state_d = fas_ok_i ? ST_LOCK : ST_HUNT;
          miss_d  = '0;
        end
        ST_LOCK: if (chk_i) begin
          if (word_ok) begin
            miss_d = '0;
          end else if (miss_q == MW'(LOSS_LIMIT - 1)) begin
            state_d = ST_HUNT;
            miss_d  = '0;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
        ST_HOLD: if (chk_i && fas_frame_i) state_d = ST_HUNT;
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end
endmodule

// File: rtl/e1_basic_framer.sv
module e1_basic_framer
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter int LOSS_LIMIT = 3,
  localparam int PW        = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_bit_i,
  input  logic          rx_valid_i,
  input  logic          reframe_i,
  output logic          sync_no,
  output logic          frame_start_o,
  output logic          fas_frame_o,
  output logic [PW-1:0] bit_pos_o,
  output logic          tx_rai_o,
  output logic          mf_rst_o
);
  logic [FAS_LEN-1:0] win;
  logic [PW-1:0]      nxt_pos;
  logic               nxt_fas;
  logic               load, locked, chk, fas_ok, nfas_ok, fs_q;

  e1fa_window #(.W(FAS_LEN)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rx_valid_i),
    .bit_i   (rx_bit_i),
    .win_o   (win)
  );

  assign fas_ok  = (win == FAS_WORD);
  assign nfas_ok = win[FAS_LEN-1];  // bit two of slot 0
  assign chk     = rx_valid_i && (nxt_pos == PW'(SLOT_BITS - 1));

  e1fa_pos_cnt #(.FRAME_BITS(FRAME_BITS), .LOAD_POS(SLOT_BITS - 1)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (rx_valid_i),
    .load_i    (load),
    .pos_o     (bit_pos_o),
    .fas_o     (fas_frame_o),
    .nxt_pos_o (nxt_pos),
    .nxt_fas_o (nxt_fas)
  );

  e1fa_ctrl #(.LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .reframe_i   (reframe_i),
    .chk_i       (chk),
    .fas_frame_i (nxt_fas),
    .fas_ok_i    (fas_ok),
    .nfas_ok_i   (nfas_ok),
    .load_o      (load),
    .locked_o    (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= 1'b0;
    else         fs_q <= rx_valid_i && locked && (nxt_pos == '0);
  end

  assign frame_start_o = fs_q;
  assign sync_no       = ~locked;
  assign tx_rai_o      = ~locked;
  assign mf_rst_o      = ~locked;
endmodule

// File: rtl/e1_basic_framer_chk.sv
module e1_basic_framer_chk #(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  localparam int PW        = $clog2(FRAME_BITS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          reframe_i,
  input logic          sync_no,
  input logic          frame_start_o,
  input logic          fas_frame_o,
  input logic [PW-1:0] bit_pos_o
);
  p_lock_at_fas_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_no) |-> (bit_pos_o == PW'(SLOT_BITS - 1)) && fas_frame_o);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(bit_pos_o) && $stable(fas_frame_o));

  p_step_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_no && rx_valid_i) |=> bit_pos_o == PW'($past(bit_pos_o) + 1'b1));

  p_start_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (bit_pos_o == '0) && !sync_no);

  p_loss_at_ts0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_no) && !$past(reframe_i)) |-> bit_pos_o == PW'(SLOT_BITS - 1));

  p_reframe_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_i |=> sync_no);
endmodule

bind e1_basic_framer e1_basic_framer_chk #(
  .FRAME_BITS (FRAME_BITS),
  .SLOT_BITS  (SLOT_BITS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_i    (rx_valid_i),
  .reframe_i     (reframe_i),
  .sync_no       (sync_no),
  .frame_start_o (frame_start_o),
  .fas_frame_o   (fas_frame_o),
  .bit_pos_o     (bit_pos_o)
);

// File: tb/e1_basic_framer_test.sv
`timescale 1ns/1ps
module e1_basic_framer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_bit_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic       reframe_i = 1'b0;
  logic       sync_no, frame_start_o, fas_frame_o, tx_rai_o, mf_rst_o;
  logic [7:0] bit_pos_o;

  localparam logic [6:0] FAS = 7'b0011011;

  int n_cmp = 0;
  int n_bad = 0;

  int g_pos;
  bit g_fas;
  bit prev_bit;
  bit bad_ts0;
  int fas_ends;

  always #2.5 clk_i = ~clk_i;

  e1_basic_framer uut (
    .clk_i, .rst_ni, .rx_bit_i, .rx_valid_i, .reframe_i,
    .sync_no, .frame_start_o, .fas_frame_o, .bit_pos_o, .tx_rai_o, .mf_rst_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit gen_bit();
    bit b;
    if (g_pos < 8) begin
      if (g_pos == 0)  b = 1'b1;
      else if (g_fas)  b = (bad_ts0 && g_pos == 5) ? 1'b1 : FAS[7 - g_pos];
      else if (g_pos == 1) b = !bad_ts0;
      else             b = 1'b1;
    end else begin
      // no two zeros in a row: only the alignment word can match
      b = prev_bit ? 1'($urandom_range(0, 1)) : 1'b1;
    end
    return b;
  endfunction

  task automatic step(input bit exp_lock);
    bit b;
    int cp;
    bit cf;
    int idle;
    b = gen_bit();
    @(negedge clk_i);
    rx_bit_i = b;
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    prev_bit = b;
    cp = g_pos;
    cf = g_fas;
    if (cp == 7 && cf && !bad_ts0) fas_ends++;
    if (cp == 7) bad_ts0 = 1'b0;
    g_pos++;
    if (g_pos == 256) begin
      g_pos = 0;
      g_fas = !g_fas;
    end
    chk(sync_no == !exp_lock, "R4/R7 sync_no", int'(sync_no), int'(!exp_lock));
    chk(tx_rai_o == !exp_lock && mf_rst_o == !exp_lock, "R10 rai/mf_rst",
        int'({tx_rai_o, mf_rst_o}), exp_lock ? 0 : 3);
    chk(frame_start_o == (exp_lock && cp == 0), "R6 frame_start",
        int'(frame_start_o), int'(exp_lock && cp == 0));
    if (exp_lock) begin
      chk(bit_pos_o == 8'(cp), "R5 bit_pos", int'(bit_pos_o), cp);
      chk(fas_frame_o == cf, "R5 fas_frame", int'(fas_frame_o), int'(cf));
    end
    idle = $urandom_range(0, 2);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk_i);
      if (exp_lock) chk(bit_pos_o == 8'(cp), "R5 idle hold", int'(bit_pos_o), cp);
      chk(frame_start_o == 1'b0, "R6 single pulse", int'(frame_start_o), 0);
    end
  endtask

  // run through the next slot-0 word, optionally corrupted
  task automatic run_ts0(input bit bad, input bit exp_mid, input bit exp_end);
    bad_ts0 = bad;
    while (g_pos != 7) step(exp_mid);
    step(exp_end);
  endtask

  // alignment expected exactly at the k-th good alignment word
  task automatic acquire(input int k);
    bit last;
    fas_ends = 0;
    forever begin
      last = (g_pos == 7) && g_fas && (fas_ends == k - 1);
      step(last);
      if (last) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1e1f));
    repeat (3) @(negedge clk_i);
    chk(sync_no && tx_rai_o && mf_rst_o, "R1 flags in reset",
        int'({sync_no, tx_rai_o, mf_rst_o}), 7);
    chk(!frame_start_o && bit_pos_o == 0 && !fas_frame_o, "R1 counters in reset",
        int'({frame_start_o, fas_frame_o, bit_pos_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sync_no && tx_rai_o && mf_rst_o, "R1 flags after reset",
        int'({sync_no, tx_rai_o, mf_rst_o}), 7);
    chk(bit_pos_o == 0 && !fas_frame_o, "R1 position after reset", int'(bit_pos_o), 0);

    // R2/R4: random offset, lock at second good alignment word
    g_pos = $urandom_range(8, 255);
    g_fas = 1'($urandom_range(0, 1));
    prev_bit = 1'b1;
    bad_ts0 = 1'b0;
    acquire(2);
    for (int i = 0; i < 4; i++) run_ts0(0, 1, 1);

    // R7: two misses then a pass keep alignment; three in a row lose it
    run_ts0(1, 1, 1);
    run_ts0(1, 1, 1);
    run_ts0(0, 1, 1);
    run_ts0(1, 1, 1);
    run_ts0(1, 1, 1);
    run_ts0(1, 1, 0);

    // R9 + R3: hunt resumes at once; bad bit two rejects candidate
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(1, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 1);

    // R7 loss on non-alignment frame, then R9 wrong confirming word
    run_ts0(1, 1, 1);
    run_ts0(1, 1, 1);
    run_ts0(1, 1, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(1, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 0);
    run_ts0(0, 0, 1);

    // R8: manual reframe mid-frame, current slot skipped
    run_ts0(0, 1, 1);
    while (g_pos != 100) step(1);
    @(negedge clk_i);
    reframe_i = 1'b1;
    @(negedge clk_i);
    reframe_i = 1'b0;
    chk(sync_no == 1'b1, "R8 reframe drops sync", int'(sync_no), 1);
    acquire(3);
    run_ts0(0, 1, 1);
    run_ts0(0, 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule